// File: doc/BRIEF.md
# Pipeline-Stage Built-In Self-Test Controller

This block sits around the four combinational units of a five-stage 16-bit pipelined core: the control decoder and the address adder in decode, the ALU and the branch evaluator in execute. A reserved test opcode acts as a no-op for the program. While it occupies a stage, that stage's two units take their operands from private pseudo-random generators instead of the functional operands. Their results are folded into private signature registers in the same cycle. The functional result registers of a unit under test keep their value, so no architectural state moves.

The test opcode is recognised in decode from the opcode field and follows the pipe into execute one cycle later. A single test opcode therefore exercises all four units over two cycles. A synchronous clear restarts every generator from its seed and empties every signature. A compare strobe judges each unit against a programmable expected signature and latches a per-unit and an overall pass flag.

Top module: `pipe_selftest_ctrl`

## Requirements
- R1: A synchronous active-high reset zeroes every signature, every functional result register, unit_pass, pass_all and ex_test_en, and loads every generator with its seed.
- R2: id_test_en is high exactly in the cycles where id_op equals the test opcode (default 4'hF). ex_test_en equals id_test_en of the previous cycle.
- R3: A decode test cycle updates only the control (unit 0) and adder (unit 1) signatures. An execute test cycle updates only the ALU (unit 2) and branch (unit 3) signatures. Both happen at the clock edge that ends that cycle.
- R4: A generator steps as s' = (s>>1) ^ (s[0] ? P : 0) over 32 bits, and a signature as m' = ((m>>1) ^ (m[0] ? 16'hB400 : 0)) ^ y, where y is the unit output. The default P are 80200003, D0000001, 80000EA6 and A3000000 (hex, units 0 to 3), and the default seeds are 1F2E3D4C, C0FFEE11, 2468ACE1 and 13579BDF. In test, the unit's 36-bit operand word is {s[31:28], s}, with a = bits 15:0, b = bits 31:16 and sel = bits 35:32.
- R5: Outside its stage's test cycles, a unit's generator and signature hold their value.
- R6: A unit's functional result register loads the unit output on every cycle outside its stage's test cycles and holds during them. The test opcode therefore leaves the results unchanged.
- R7: Unit functions. Control: (1 << op) ^ flags, with op = id_op and flags = id_flags. Adder: a + b. ALU, by ex_fn: 0 add, 1 a-b, 2 and, 3 xor. Branch: taken by ex_cond (0 never, 1 always, 2 zero flag ex_zc[0], 3 carry flag ex_zc[1]); the result is a+b when taken and a+1 otherwise.
- R8: clr reloads every seed and zeroes every signature at the next edge. This wins over a coincident test cycle. clr leaves the results and the pass flags alone.
- R9: cmp_go latches unit_pass[i] = (signature i == expected i), with pass_all high only when all four match. Both hold while cmp_go is low.
- R10: sig_flat and exp_flat hold unit i in bits [16i+15:16i], in the order control, adder, ALU, branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Restart generators and empty signatures |
| cmp_go | input | 1 | Latch pass flags against exp_flat |
| id_op | input | 4 | Opcode field of the instruction in decode |
| id_flags | input | 4 | Status bits feeding the control decoder |
| id_a | input | 16 | Adder operand a |
| id_b | input | 16 | Adder operand b |
| ex_a | input | 16 | Execute operand a (ALU, branch base) |
| ex_b | input | 16 | Execute operand b (ALU, branch offset) |
| ex_fn | input | 2 | ALU function code |
| ex_cond | input | 2 | Branch condition code |
| ex_zc | input | 2 | Branch flags: [0] zero, [1] carry |
| exp_flat | input | 64 | Expected signatures, unit i at [16i+15:16i] |
| id_test_en | output | 1 | Decode units in test this cycle |
| ex_test_en | output | 1 | Execute units in test this cycle |
| id_ctrl_q | output | 16 | Registered control word |
| id_sum_q | output | 16 | Registered adder result |
| ex_alu_q | output | 16 | Registered ALU result |
| ex_br_q | output | 16 | Registered branch target |
| sig_flat | output | 64 | Current signatures, unit i at [16i+15:16i] |
| unit_pass | output | 4 | Per-unit signature match, latched by cmp_go |
| pass_all | output | 1 | All four units matched at the last compare |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a test opcode in decode while the previous test opcode sits in execute. Here a clear, two signature updates and a result hold all compete at one edge. The stimulus forces this overlap directly, with back-to-back test opcodes and clr pulses placed on and beside them, and also reaches it in a long random phase. Meaningful compare results need expected signatures that match the design's real ones. The bench's behavioural model supplies those at the moment of each cmp_go, and one pass deliberately corrupts only the ALU's expected field to show the field position.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int DW  = 16;
  localparam int LW  = 2 * DW;
  localparam int SW  = 4;
  localparam int IW  = LW + SW;
  localparam int NU  = 4;
  localparam int OPW = $clog2(DW);

  typedef enum logic [1:0] {
    U_CTRL = 2'd0,
    U_ADD  = 2'd1,
    U_ALU  = 2'd2,
    U_BR   = 2'd3
  } unit_kind_e;

  // Behavioural models of the four combinational units.
  function automatic logic [DW-1:0] unit_eval(input unit_kind_e kind,
                                              input logic [IW-1:0] w);
    logic [DW-1:0] a, b, y;
    logic [SW-1:0] sel;
    logic          taken;
    a     = w[DW-1:0];
    b     = w[LW-1:DW];
    sel   = w[IW-1:LW];
    taken = 1'b0;
    y     = '0;
    case (kind)
      U_CTRL: y = (DW'(1) << w[OPW-1:0]) ^ DW'(w[2*OPW-1:OPW]);
      U_ADD:  y = a + b;
      U_ALU: begin
        case (sel[1:0])
          2'd0:    y = a + b;
          2'd1:    y = a - b;
          2'd2:    y = a & b;
          default: y = a ^ b;
        endcase
      end
      default: begin
        case (sel[1:0])
          2'd0:    taken = 1'b0;
          2'd1:    taken = 1'b1;
          2'd2:    taken = sel[2];
          default: taken = sel[3];
        endcase
        y = taken ? (a + b) : (a + DW'(1));
      end
    endcase
    return y;
  endfunction
endpackage

// File: rtl/sbt_lfsr.sv
module sbt_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = 32'h80200003,
  parameter logic [W-1:0] SEED = 32'h00000001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst || load)
      state <= SEED;
    else if (step)
      state <= {1'b0, state[W-1:1]} ^ (state[0] ? POLY : '0);
  end
endmodule

// File: rtl/sbt_misr.sv
module sbt_misr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      sig <= '0;
    else if (en)
      sig <= ({1'b0, sig[W-1:1]} ^ (sig[0] ? POLY : '0)) ^ din;
  end
endmodule

// File: rtl/sbt_lane.sv
module sbt_lane import sbt_pkg::*; #(
  parameter unit_kind_e    KIND  = U_ADD,
  parameter logic [LW-1:0] POLY  = 32'h80200003,
  parameter logic [LW-1:0] SEED  = 32'h00000001,
  parameter logic [DW-1:0] MPOLY = 16'hB400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          test_en,
  input  logic [IW-1:0] func_w,
  output logic [DW-1:0] sig,
  output logic [DW-1:0] res_q
);
  logic [LW-1:0] lfsr_q;
  logic [IW-1:0] stim, opw;
  logic [DW-1:0] y;

  sbt_lfsr #(.W(LW), .POLY(POLY), .SEED(SEED)) u_gen (
    .clk(clk), .rst(rst), .load(clr), .step(test_en), .state(lfsr_q)
  );

  // Generator word fills both operands; its top nibble doubles as selector.
  assign stim = {lfsr_q[LW-1:LW-SW], lfsr_q};
  assign opw  = test_en ? stim : func_w;
  assign y    = unit_eval(KIND, opw);

  sbt_misr #(.W(DW), .POLY(MPOLY)) u_sig (
    .clk(clk), .rst(rst), .clr(clr), .en(test_en), .din(y), .sig(sig)
  );

  // Functional result register stays untouched while under test.
  always_ff @(posedge clk) begin
    if (rst)
      res_q <= '0;
    else if (!test_en)
      res_q <= y;
  end
endmodule

// File: rtl/pipe_selftest_ctrl.sv
module pipe_selftest_ctrl import sbt_pkg::*; #(
  parameter logic [OPW-1:0]   TEST_OP = '1,
  parameter logic [NU*LW-1:0] POLYS   = {32'hA3000000, 32'h80000EA6,
                                         32'hD0000001, 32'h80200003},
  parameter logic [NU*LW-1:0] SEEDS   = {32'h13579BDF, 32'h2468ACE1,
                                         32'hC0FFEE11, 32'h1F2E3D4C},
  parameter logic [DW-1:0]    MPOLY   = 16'hB400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cmp_go,
  input  logic [OPW-1:0]   id_op,
  input  logic [OPW-1:0]   id_flags,
  input  logic [DW-1:0]    id_a,
  input  logic [DW-1:0]    id_b,
  input  logic [DW-1:0]    ex_a,
  input  logic [DW-1:0]    ex_b,
  input  logic [1:0]       ex_fn,
  input  logic [1:0]       ex_cond,
  input  logic [1:0]       ex_zc,
  input  logic [NU*DW-1:0] exp_flat,
  output logic             id_test_en,
  output logic             ex_test_en,
  output logic [DW-1:0]    id_ctrl_q,
  output logic [DW-1:0]    id_sum_q,
  output logic [DW-1:0]    ex_alu_q,
  output logic [DW-1:0]    ex_br_q,
  output logic [NU*DW-1:0] sig_flat,
  output logic [NU-1:0]    unit_pass,
  output logic             pass_all
);
  localparam int NID = 2;   // units 0..NID-1 live in decode, rest in execute

  logic [IW-1:0] fw   [NU];
  logic [DW-1:0] res  [NU];
  logic [NU-1:0] lane_te;
  logic [NU-1:0] eq;

  // Test opcode decode and its trip into execute.
  assign id_test_en = (id_op == TEST_OP);

  always_ff @(posedge clk) begin
    if (rst) ex_test_en <= 1'b0;
    else     ex_test_en <= id_test_en;
  end

  // Functional operand words, laid out as {sel, b, a}.
  assign fw[0] = {{(IW-2*OPW){1'b0}}, id_flags, id_op};
  assign fw[1] = {{SW{1'b0}}, id_b, id_a};
  assign fw[2] = {{(SW-2){1'b0}}, ex_fn, ex_b, ex_a};
  assign fw[3] = {ex_zc, ex_cond, ex_b, ex_a};

  for (genvar u = 0; u < NU; u++) begin : g_lane
    assign lane_te[u] = (u < NID) ? id_test_en : ex_test_en;

    sbt_lane #(
      .KIND (unit_kind_e'(u)),
      .POLY (POLYS[u*LW +: LW]),
      .SEED (SEEDS[u*LW +: LW]),
      .MPOLY(MPOLY)
    ) u_lane (
      .clk(clk), .rst(rst), .clr(clr), .test_en(lane_te[u]),
      .func_w(fw[u]), .sig(sig_flat[u*DW +: DW]), .res_q(res[u])
    );

    assign eq[u] = (sig_flat[u*DW +: DW] == exp_flat[u*DW +: DW]);
  end

  assign id_ctrl_q = res[0];
  assign id_sum_q  = res[1];
  assign ex_alu_q  = res[2];
  assign ex_br_q   = res[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_pass <= '0;
      pass_all  <= 1'b0;
    end else if (cmp_go) begin
      unit_pass <= eq;
      pass_all  <= &eq;
    end
  end
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker (
  input logic        clk,
  input logic        rst,
  input logic        clr,
  input logic        cmp_go,
  input logic        id_test_en,
  input logic        ex_test_en,
  input logic [15:0] id_ctrl_q,
  input logic [15:0] id_sum_q,
  input logic [15:0] ex_alu_q,
  input logic [15:0] ex_br_q,
  input logic [63:0] sig_flat,
  input logic [3:0]  unit_pass,
  input logic        pass_all
);
  assert_ex_follows_id_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ex_test_en == $past(id_test_en)));

  assert_id_sig_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr) && !$past(id_test_en)) |-> $stable(sig_flat[31:0]));

  assert_ex_sig_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr) && !$past(ex_test_en)) |-> $stable(sig_flat[63:32]));

  assert_id_res_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(id_test_en)) |-> ($stable(id_ctrl_q) && $stable(id_sum_q)));

  assert_ex_res_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ex_test_en)) |-> ($stable(ex_alu_q) && $stable(ex_br_q)));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr)) |-> (sig_flat == 64'h0));

  assert_pass_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cmp_go)) |-> ($stable(unit_pass) && $stable(pass_all)));

  assert_pass_all_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_all) |-> $past(cmp_go));
endmodule

bind pipe_selftest_ctrl sbt_checker u_chk (
  .clk(clk), .rst(rst), .clr(clr), .cmp_go(cmp_go),
  .id_test_en(id_test_en), .ex_test_en(ex_test_en),
  .id_ctrl_q(id_ctrl_q), .id_sum_q(id_sum_q),
  .ex_alu_q(ex_alu_q), .ex_br_q(ex_br_q),
  .sig_flat(sig_flat), .unit_pass(unit_pass), .pass_all(pass_all)
);

// File: tb/sim_pipe_selftest_ctrl.sv
`timescale 1ns/1ps
module sim_pipe_selftest_ctrl;
  logic        clk = 1'b0;
  logic        rst, clr, cmp_go;
  logic [3:0]  id_op, id_flags;
  logic [15:0] id_a, id_b, ex_a, ex_b;
  logic [1:0]  ex_fn, ex_cond, ex_zc;
  logic [63:0] exp_flat;
  logic        id_test_en, ex_test_en, pass_all;
  logic [15:0] id_ctrl_q, id_sum_q, ex_alu_q, ex_br_q;
  logic [63:0] sig_flat;
  logic [3:0]  unit_pass;

  always #4 clk = ~clk;   // 125 MHz

  pipe_selftest_ctrl u0 (
    .clk(clk), .rst(rst), .clr(clr), .cmp_go(cmp_go),
    .id_op(id_op), .id_flags(id_flags), .id_a(id_a), .id_b(id_b),
    .ex_a(ex_a), .ex_b(ex_b), .ex_fn(ex_fn), .ex_cond(ex_cond), .ex_zc(ex_zc),
    .exp_flat(exp_flat), .id_test_en(id_test_en), .ex_test_en(ex_test_en),
    .id_ctrl_q(id_ctrl_q), .id_sum_q(id_sum_q), .ex_alu_q(ex_alu_q),
    .ex_br_q(ex_br_q), .sig_flat(sig_flat), .unit_pass(unit_pass),
    .pass_all(pass_all)
  );

  // Values taken from the requirements.
  localparam logic [31:0] GPOLY [4] = '{32'h80200003, 32'hD0000001,
                                        32'h80000EA6, 32'hA3000000};
  localparam logic [31:0] GSEED [4] = '{32'h1F2E3D4C, 32'hC0FFEE11,
                                        32'h2468ACE1, 32'h13579BDF};

  int    vectors = 0, miscompares = 0;
  bit    chk_on = 0, done = 0;
  string cur_tag = "R1";

  // Reference model state
  logic [31:0] m_gen [4];
  logic [15:0] m_sig [4];
  logic [15:0] m_res [4];
  logic [3:0]  m_pass;
  logic        m_all, m_ext;

  function automatic logic [15:0] ref_unit(input int u, input logic [35:0] w);
    logic [15:0] a = w[15:0];
    logic [15:0] b = w[31:16];
    logic        tk;
    case (u)
      0: return (16'h0001 << w[3:0]) ^ {12'h000, w[7:4]};
      1: return a + b;
      2: begin
        if (w[33:32] == 2'd0)      return a + b;
        else if (w[33:32] == 2'd1) return a - b;
        else if (w[33:32] == 2'd2) return a & b;
        else                       return a ^ b;
      end
      default: begin
        tk = (w[33:32] == 2'd1) || (w[33:32] == 2'd2 && w[34]) ||
             (w[33:32] == 2'd3 && w[35]);
        return tk ? a + b : a + 16'd1;
      end
    endcase
  endfunction

  function automatic logic [35:0] func_word(input int u);
    case (u)
      0: return {28'h0, id_flags, id_op};
      1: return {4'h0, id_b, id_a};
      2: return {2'b00, ex_fn, ex_b, ex_a};
      default: return {ex_zc[1], ex_zc[0], ex_cond, ex_b, ex_a};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < 4; u++) begin
        m_gen[u] = GSEED[u]; m_sig[u] = 16'h0; m_res[u] = 16'h0;
      end
      m_pass = 4'h0; m_all = 1'b0; m_ext = 1'b0;
    end else begin
      logic idt;
      logic [3:0] e;
      idt = (id_op == 4'hF);
      for (int u = 0; u < 4; u++) e[u] = (m_sig[u] == exp_flat[16*u +: 16]);
      if (cmp_go) begin m_pass = e; m_all = (e == 4'hF); end
      for (int u = 0; u < 4; u++) begin
        logic te;
        logic [35:0] w;
        logic [15:0] y;
        te = (u < 2) ? idt : m_ext;
        w  = te ? {m_gen[u][31:28], m_gen[u]} : func_word(u);
        y  = ref_unit(u, w);
        if (clr) begin
          m_gen[u] = GSEED[u]; m_sig[u] = 16'h0;
        end else if (te) begin
          m_sig[u] = ((m_sig[u] >> 1) ^ (m_sig[u][0] ? 16'hB400 : 16'h0)) ^ y;
          m_gen[u] = (m_gen[u] >> 1) ^ (m_gen[u][0] ? GPOLY[u] : 32'h0);
        end
        if (!te) m_res[u] = y;
      end
      m_ext = idt;
    end
    chk_on = 1;
  end

  task automatic chk(input string nm, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", cur_tag, nm, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on && !done) begin
    chk("id_test_en", 64'(id_test_en), 64'(id_op == 4'hF));
    chk("ex_test_en", 64'(ex_test_en), 64'(m_ext));
    chk("sig_flat", sig_flat, {m_sig[3], m_sig[2], m_sig[1], m_sig[0]});
    chk("id_ctrl_q", 64'(id_ctrl_q), 64'(m_res[0]));
    chk("id_sum_q", 64'(id_sum_q), 64'(m_res[1]));
    chk("ex_alu_q", 64'(ex_alu_q), 64'(m_res[2]));
    chk("ex_br_q", 64'(ex_br_q), 64'(m_res[3]));
    chk("unit_pass", 64'(unit_pass), 64'(m_pass));
    chk("pass_all", 64'(pass_all), 64'(m_all));
  end

  task automatic go();
    @(negedge clk); #1;
  endtask

  task automatic set_rand(input int test_pct);
    id_op    = ($urandom % 100 < test_pct) ? 4'hF : 4'($urandom % 15);
    id_flags = 4'($urandom); id_a = 16'($urandom); id_b = 16'($urandom);
    ex_a = 16'($urandom); ex_b = 16'($urandom);
    ex_fn = 2'($urandom); ex_cond = 2'($urandom); ex_zc = 2'($urandom);
    clr = 1'b0; cmp_go = 1'b0;
  endtask

  function automatic logic [63:0] model_sigs();
    return {m_sig[3], m_sig[2], m_sig[1], m_sig[0]};
  endfunction

  initial begin
    rst = 1'b1; exp_flat = 64'h0;
    set_rand(0); id_op = 4'hF;          // test opcode held during reset
    repeat (3) go();
    cur_tag = "R1";
    rst = 1'b0; set_rand(0);
    go();
    // R7: every ALU function and branch condition, no test opcode
    cur_tag = "R7";
    for (int i = 0; i < 48; i++) begin
      set_rand(0); ex_fn = 2'(i % 4); ex_cond = 2'((i / 4) % 4); ex_zc = 2'(i / 16);
      go();
    end
    // R3: one isolated test opcode walks decode then execute
    cur_tag = "R3";
    set_rand(0); id_op = 4'hF; go();
    for (int i = 0; i < 4; i++) begin set_rand(0); go(); end
    // R2: two back-to-back test opcodes
    cur_tag = "R2";
    set_rand(0); id_op = 4'hF; go();
    set_rand(0); id_op = 4'hF; go();
    set_rand(0); go();
    // R5: long idle stretch without test
    cur_tag = "R5";
    for (int i = 0; i < 12; i++) begin set_rand(0); go(); end
    // R6: mixed test and functional cycles
    cur_tag = "R6";
    for (int i = 0; i < 24; i++) begin set_rand(50); go(); end
    // R8: clear alone, clear on a decode test, clear on an execute test
    cur_tag = "R8";
    set_rand(0); clr = 1'b1; go();
    set_rand(0); id_op = 4'hF; go();
    set_rand(0); id_op = 4'hF; clr = 1'b1; go();
    set_rand(0); clr = 1'b1; go();
    set_rand(0); id_op = 4'hF; go();
    set_rand(0); go();
    // R9: compare with the true signatures
    cur_tag = "R9";
    set_rand(0); exp_flat = model_sigs(); cmp_go = 1'b1; go();
    set_rand(0); exp_flat = 64'h0; go();
    // R10: corrupt only the ALU field (bits 47:32)
    cur_tag = "R10";
    set_rand(0); exp_flat = model_sigs() ^ 64'h0000_0001_0000_0000; cmp_go = 1'b1; go();
    set_rand(0); go();
    // R4: long random mix with clears and compares
    cur_tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      set_rand(30);
      if ($urandom % 100 == 0) clr = 1'b1;
      if ($urandom % 50 == 0) begin
        cmp_go = 1'b1;
        exp_flat = ($urandom % 2 == 0) ? model_sigs() : 64'($urandom);
      end
      go();
    end
    set_rand(0); go();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule